// File: doc/BRIEF.md
# System Clock Source Switch Controller

This block decides which of four clock sources drives the system clock. Software writes a 2-bit source request. The block issues an effective select to the external glitch-free clock mux and reports the source actually in use on a separate 2-bit status output. A requested switch goes ahead only once the target source reports ready. The status output changes only after a fixed handshake window has elapsed, so it lags the request until the switch completes.

Hardware events take precedence over software. A wake-up from standby or shutdown forces the low-power internal oscillator. A wake-up from stop mode, or a failure of the external oscillator, forces a fallback source chosen by a preference bit: either the low-power internal oscillator or the 16 MHz internal oscillator. A forced fallback takes effect on the next clock edge. It rewrites the request register, so a readback of the request shows the forced source.

Top module: `sysclk_switch`

## Requirements
- R1: While `rst` is high, every clock edge sets `req_q`, `mux_sel` and `status` to 00.
- R2: Source codes are 00 for the low-power internal oscillator, 01 for the 16 MHz internal oscillator, 10 for the external oscillator and 11 for the PLL. A clock edge with `sw_wr` high loads `sw_sel` into `req_q`.
- R3: When `req_q` differs from `status` and the requested source's bit in `src_rdy` is 1, `mux_sel` takes the requested code on the next edge. `status` takes the same code `HS_CYCLES` edges later (default 2).
- R4: Outside forced events, `status` only ever takes a code whose `src_rdy` bit was 1. While the requested source is not ready, `status` and `mux_sel` keep the old source.
- R5: If the target's `src_rdy` bit drops during the handshake window, the switch is abandoned. `mux_sel` returns to the `status` code on the next edge and `status` is unchanged. The switch restarts once the source is ready again.
- R6: A `wake_stby` pulse sets `req_q`, `mux_sel` and `status` to 00 on the next edge, whatever `stop_wake_int` is.
- R7: A `wake_stop` pulse sets all three outputs to 01 when `stop_wake_int` is 1, and to 00 when it is 0, on the next edge.
- R8: An `ext_fail` pulse forces the same fallback as R7, on the next edge. This also applies during a handshake window, which it abandons.
- R9: A forced fallback overrides a `sw_wr` in the same cycle. The request register shows the forced code and no handshake follows. `wake_stby` overrides `wake_stop` and `ext_fail` in the same cycle.
- R10: A request equal to the current `status` starts no switch, and `mux_sel` and `status` stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_wr | input | 1 | Software write strobe for the request |
| sw_sel | input | 2 | Requested source code |
| src_rdy | input | 4 | Ready flag per source, indexed by source code |
| wake_stop | input | 1 | Pulse: exit from stop mode |
| wake_stby | input | 1 | Pulse: exit from standby or shutdown |
| ext_fail | input | 1 | Pulse: external oscillator failure detected |
| stop_wake_int | input | 1 | Fallback preference: 1 = 16 MHz internal, 0 = low-power internal |
| req_q | output | 2 | Request register readback |
| mux_sel | output | 2 | Effective select to the clock mux |
| status | output | 2 | Source actually driving the system clock |

## Verification
Several functions can fall in the same cycle, and the bench provokes three such collisions.

- A software write to the PLL is driven in the same cycle as an external-oscillator failure. The check is that the request readback, the select and the status all show the fallback, and that no handshake starts afterwards.
- A failure pulse arrives while a handshake window is open. The pending switch must be dropped in favour of the fallback on the very next edge.
- Standby and stop wake-ups are raised together with the preference bit set. The check is that the standby target wins.

// File: rtl/sysclk_sw_pkg.sv
package sysclk_sw_pkg;
  localparam int SRC_W = 2;
  localparam int NSRC  = 1 << SRC_W;

  typedef enum logic [SRC_W-1:0] {
    SRC_LPOSC  = 2'b00,
    SRC_INTOSC = 2'b01,
    SRC_XOSC   = 2'b10,
    SRC_PLL    = 2'b11
  } src_e;

  typedef enum logic {
    HS_IDLE,
    HS_WAIT
  } hs_state_e;
endpackage

// File: rtl/sysclk_force_sel.sv
module sysclk_force_sel
  import sysclk_sw_pkg::*;
(
  input  logic wake_stop,
  input  logic wake_stby,
  input  logic ext_fail,
  input  logic stop_wake_int,
  output logic force_vld,
  output src_e force_src
);
  // Standby exit always lands on the low-power oscillator; stop exit and
  // oscillator failure share the preference-dependent fallback.
  always_comb begin
    force_vld = wake_stop | wake_stby | ext_fail;
    if (wake_stby)
      force_src = SRC_LPOSC;
    else if (stop_wake_int)
      force_src = SRC_INTOSC;
    else
      force_src = SRC_LPOSC;
  end
endmodule

// File: rtl/sysclk_req_reg.sv
module sysclk_req_reg
  import sysclk_sw_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             force_vld,
  input  src_e             force_src,
  input  logic             sw_wr,
  input  logic [SRC_W-1:0] sw_sel,
  output src_e             req_q
);
  always_ff @(posedge clk) begin
    if (rst)
      req_q <= SRC_LPOSC;
    else if (force_vld)
      req_q <= force_src;
    else if (sw_wr)
      req_q <= src_e'(sw_sel);
  end
endmodule

// File: rtl/sysclk_hs.sv
module sysclk_hs
  import sysclk_sw_pkg::*;
#(
  parameter int HS_CYCLES = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  src_e            req,
  input  logic [NSRC-1:0] src_rdy,
  input  logic            force_vld,
  input  src_e            force_src,
  output src_e            mux_sel,
  output src_e            status
);
  localparam int CNT_W = (HS_CYCLES > 1) ? $clog2(HS_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HS_CYCLES - 1);

  hs_state_e        state_q;
  src_e             tgt_q;
  logic [CNT_W-1:0] cnt_q;
  logic             start_ok;
  logic             abort;

  always_comb begin
    start_ok = (req != status) && src_rdy[req];
    abort    = (req != tgt_q) || !src_rdy[tgt_q];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= HS_IDLE;
      tgt_q   <= SRC_LPOSC;
      cnt_q   <= '0;
      mux_sel <= SRC_LPOSC;
      status  <= SRC_LPOSC;
    end else if (force_vld) begin
      state_q <= HS_IDLE;
      tgt_q   <= force_src;
      cnt_q   <= '0;
      mux_sel <= force_src;
      status  <= force_src;
    end else begin
      unique case (state_q)
        HS_IDLE: begin
          if (start_ok) begin
            state_q <= HS_WAIT;
            tgt_q   <= req;
            mux_sel <= req;
            cnt_q   <= '0;
          end
        end
        HS_WAIT: begin
          if (abort) begin
            state_q <= HS_IDLE;
            mux_sel <= status;
          end else if (cnt_q == CNT_LAST) begin
            state_q <= HS_IDLE;
            status  <= tgt_q;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: state_q <= HS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sysclk_switch.sv
module sysclk_switch
  import sysclk_sw_pkg::*;
#(
  parameter int HS_CYCLES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sw_wr,
  input  logic [1:0]       sw_sel,
  input  logic [3:0]       src_rdy,
  input  logic             wake_stop,
  input  logic             wake_stby,
  input  logic             ext_fail,
  input  logic             stop_wake_int,
  output logic [1:0]       req_q,
  output logic [1:0]       mux_sel,
  output logic [1:0]       status
);
  logic force_vld;
  src_e force_src;
  src_e req_e;
  src_e mux_e;
  src_e stat_e;

  sysclk_force_sel u_force (
    .wake_stop    (wake_stop),
    .wake_stby    (wake_stby),
    .ext_fail     (ext_fail),
    .stop_wake_int(stop_wake_int),
    .force_vld    (force_vld),
    .force_src    (force_src)
  );

  sysclk_req_reg u_req (
    .clk      (clk),
    .rst      (rst),
    .force_vld(force_vld),
    .force_src(force_src),
    .sw_wr    (sw_wr),
    .sw_sel   (sw_sel),
    .req_q    (req_e)
  );

  sysclk_hs #(.HS_CYCLES(HS_CYCLES)) u_hs (
    .clk      (clk),
    .rst      (rst),
    .req      (req_e),
    .src_rdy  (src_rdy),
    .force_vld(force_vld),
    .force_src(force_src),
    .mux_sel  (mux_e),
    .status   (stat_e)
  );

  assign req_q   = req_e;
  assign mux_sel = mux_e;
  assign status  = stat_e;
endmodule

// File: rtl/sysclk_switch_chk.sv
module sysclk_switch_chk (
  input logic       clk,
  input logic       rst,
  input logic       sw_wr,
  input logic [1:0] sw_sel,
  input logic [3:0] src_rdy,
  input logic       wake_stop,
  input logic       wake_stby,
  input logic       ext_fail,
  input logic       stop_wake_int,
  input logic [1:0] req_q,
  input logic [1:0] mux_sel,
  input logic [1:0] status
);
  logic any_force;
  logic mux_rdy;
  assign any_force = wake_stop | wake_stby | ext_fail;
  assign mux_rdy   = src_rdy[mux_sel];

  assert_reset_R1: assert property (@(posedge clk)
    rst |=> (req_q == 2'b00 && mux_sel == 2'b00 && status == 2'b00));

  assert_write_R2: assert property (@(posedge clk) disable iff (rst)
    (sw_wr && !any_force) |=> (req_q == $past(sw_sel)));

  assert_status_from_sel_R3: assert property (@(posedge clk) disable iff (rst)
    (status != $past(status) && !$past(any_force)) |-> (status == $past(mux_sel)));

  assert_ready_only_R4: assert property (@(posedge clk) disable iff (rst)
    (status != $past(status) && !$past(any_force)) |-> $past(mux_rdy));

  assert_stby_R6: assert property (@(posedge clk) disable iff (rst)
    wake_stby |=> (req_q == 2'b00 && mux_sel == 2'b00 && status == 2'b00));

  assert_stop_R7: assert property (@(posedge clk) disable iff (rst)
    (wake_stop && !wake_stby) |=>
      (status == {1'b0, $past(stop_wake_int)} && req_q == {1'b0, $past(stop_wake_int)}));

  assert_fail_R8: assert property (@(posedge clk) disable iff (rst)
    (ext_fail && !wake_stby) |=>
      (mux_sel == {1'b0, $past(stop_wake_int)} && status == {1'b0, $past(stop_wake_int)}));
endmodule

bind sysclk_switch sysclk_switch_chk chk_i (
  .clk          (clk),
  .rst          (rst),
  .sw_wr        (sw_wr),
  .sw_sel       (sw_sel),
  .src_rdy      (src_rdy),
  .wake_stop    (wake_stop),
  .wake_stby    (wake_stby),
  .ext_fail     (ext_fail),
  .stop_wake_int(stop_wake_int),
  .req_q        (req_q),
  .mux_sel      (mux_sel),
  .status       (status)
);

// File: tb/sysclk_switch_tb_top.sv
module sysclk_switch_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sw_wr = 1'b0;
  logic [1:0] sw_sel = 2'b00;
  logic [3:0] src_rdy = 4'b0111;
  logic       wake_stop = 1'b0;
  logic       wake_stby = 1'b0;
  logic       ext_fail = 1'b0;
  logic       stop_wake_int = 1'b0;
  logic [1:0] req_q;
  logic [1:0] mux_sel;
  logic [1:0] status;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 1'b0;

  typedef struct {
    int         at;
    logic [1:0] st;
    logic [1:0] mx;
    logic [1:0] rq;
    string      tag;
  } exp_t;
  exp_t exp_q[$];

  always #2 clk = ~clk;

  sysclk_switch #(.HS_CYCLES(2)) dut_i (
    .clk(clk), .rst(rst), .sw_wr(sw_wr), .sw_sel(sw_sel), .src_rdy(src_rdy),
    .wake_stop(wake_stop), .wake_stby(wake_stby), .ext_fail(ext_fail),
    .stop_wake_int(stop_wake_int), .req_q(req_q), .mux_sel(mux_sel), .status(status)
  );

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(string tag, logic [1:0] st, logic [1:0] mx, logic [1:0] rq);
    checks++;
    if (status !== st || mux_sel !== mx || req_q !== rq) begin
      fails++;
      $display("FAIL %s cyc=%0d actual st=%b mx=%b rq=%b expected st=%b mx=%b rq=%b",
               tag, cyc, status, mux_sel, req_q, st, mx, rq);
    end
  endtask

  // monitor: pops expected items once their cycle is reached
  always @(negedge clk) begin
    while (exp_q.size() > 0 && exp_q[0].at <= cyc) begin
      exp_t e;
      e = exp_q.pop_front();
      chk(e.tag, e.st, e.mx, e.rq);
    end
  end

  task automatic expect_at(int at, logic [1:0] st, logic [1:0] mx, logic [1:0] rq, string tag);
    exp_t e;
    e.at = at; e.st = st; e.mx = mx; e.rq = rq; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sw_write(logic [1:0] v);
    sw_sel = v; sw_wr = 1'b1;
    tick(1);
    sw_wr = 1'b0;
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    int b;
    tick(3);
    rst = 1'b0;
    chk("R1 reset", 2'b00, 2'b00, 2'b00);
    tick(2);

    // R2 R3: switch to 16 MHz internal oscillator
    b = cyc;
    expect_at(b+1, 2'b00, 2'b00, 2'b01, "R2 request load");
    expect_at(b+2, 2'b00, 2'b01, 2'b01, "R3 select issued");
    expect_at(b+3, 2'b00, 2'b01, 2'b01, "R3 status lags");
    expect_at(b+4, 2'b01, 2'b01, 2'b01, "R3 status updated");
    sw_write(2'b01);
    tick(5);

    // R4: PLL requested while not ready
    b = cyc;
    expect_at(b+1, 2'b01, 2'b01, 2'b11, "R4 held, not ready");
    expect_at(b+6, 2'b01, 2'b01, 2'b11, "R4 still held");
    sw_write(2'b11);
    tick(7);
    b = cyc;
    src_rdy = 4'b1111;
    expect_at(b+1, 2'b01, 2'b11, 2'b11, "R4 select after ready");
    expect_at(b+3, 2'b11, 2'b11, 2'b11, "R4 status after ready");
    tick(5);

    // R5: ready drops mid-handshake
    b = cyc;
    expect_at(b+1, 2'b11, 2'b11, 2'b10, "R5 request load");
    expect_at(b+2, 2'b11, 2'b10, 2'b10, "R5 select issued");
    sw_write(2'b10);
    tick(1);
    src_rdy = 4'b1011;
    expect_at(b+3, 2'b11, 2'b11, 2'b10, "R5 abort select back");
    expect_at(b+5, 2'b11, 2'b11, 2'b10, "R5 status unchanged");
    tick(4);
    b = cyc;
    src_rdy = 4'b1111;
    expect_at(b+1, 2'b11, 2'b10, 2'b10, "R5 restart select");
    expect_at(b+3, 2'b10, 2'b10, 2'b10, "R5 restart status");
    tick(5);

    // R10: request equal to status
    b = cyc;
    expect_at(b+2, 2'b10, 2'b10, 2'b10, "R10 no switch");
    expect_at(b+4, 2'b10, 2'b10, 2'b10, "R10 still no switch");
    sw_write(2'b10);
    tick(5);

    // R6: standby exit ignores preference
    b = cyc;
    stop_wake_int = 1'b1;
    expect_at(b+1, 2'b00, 2'b00, 2'b00, "R6 standby fallback");
    wake_stby = 1'b1; tick(1); wake_stby = 1'b0;
    tick(3);

    // R7: stop exit both preferences
    b = cyc;
    expect_at(b+1, 2'b01, 2'b01, 2'b01, "R7 stop pref internal");
    wake_stop = 1'b1; tick(1); wake_stop = 1'b0;
    tick(3);
    b = cyc;
    stop_wake_int = 1'b0;
    expect_at(b+1, 2'b00, 2'b00, 2'b00, "R7 stop pref low-power");
    wake_stop = 1'b1; tick(1); wake_stop = 1'b0;
    tick(3);

    // R8: external oscillator failure from PLL
    b = cyc;
    expect_at(b+4, 2'b11, 2'b11, 2'b11, "R8 setup PLL");
    sw_write(2'b11);
    tick(5);
    b = cyc;
    stop_wake_int = 1'b1;
    expect_at(b+1, 2'b01, 2'b01, 2'b01, "R8 failure fallback");
    ext_fail = 1'b1; tick(1); ext_fail = 1'b0;
    tick(3);

    // R8: failure during handshake window
    b = cyc;
    expect_at(b+2, 2'b01, 2'b11, 2'b11, "R8 window open");
    sw_write(2'b11);
    tick(1);
    ext_fail = 1'b1;
    expect_at(b+3, 2'b01, 2'b01, 2'b01, "R8 window abandoned");
    expect_at(b+5, 2'b01, 2'b01, 2'b01, "R8 stays fallback");
    tick(1); ext_fail = 1'b0;
    tick(4);

    // R9: failure together with software write
    b = cyc;
    stop_wake_int = 1'b0;
    expect_at(b+1, 2'b00, 2'b00, 2'b00, "R9 force beats write");
    expect_at(b+4, 2'b00, 2'b00, 2'b00, "R9 no handshake after");
    sw_sel = 2'b11; sw_wr = 1'b1; ext_fail = 1'b1;
    tick(1);
    sw_wr = 1'b0; ext_fail = 1'b0;
    tick(5);

    // R9: standby beats stop with internal preference
    b = cyc;
    expect_at(b+4, 2'b10, 2'b10, 2'b10, "R9 setup external");
    sw_write(2'b10);
    tick(5);
    b = cyc;
    stop_wake_int = 1'b1;
    expect_at(b+1, 2'b00, 2'b00, 2'b00, "R9 standby wins");
    wake_stby = 1'b1; wake_stop = 1'b1;
    tick(1);
    wake_stby = 1'b0; wake_stop = 1'b0;
    tick(4);

    while (exp_q.size() > 0) tick(1);
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      summary();
      $finish;
    end
  end
endmodule